// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the transmit half of a packet DMA controller. A host fills a small ring of transmit descriptors kept inside the block. Each descriptor holds a flag word, a byte count and a start address in a local byte buffer. The host hands a descriptor over by setting its ready flag, then rings a doorbell. The engine walks the ring from its current position and streams each owned buffer out as bytes. When the descriptor closes a frame and asks for it, the engine appends four check bytes taken from an injected word.

After a buffer has been sent, the engine stores the injected completion status into the descriptor. On the following cycle it clears the ready flag, which returns the descriptor to the host, and it raises per-buffer and per-frame event pulses. A set wrap flag moves the engine back to entry 0, and so does running past the last entry. The engine rests on the first descriptor it finds not ready and waits there for a new doorbell.

Top module: `tx_bd_ring`

## Requirements
- R1: After reset `tx_valid`, `tx_last`, `evt_txbuf` and `evt_txframe` are 0, every flag word reads back 0, and the scan position is descriptor 0.
- R2: A doorbell write starts the engine only when `doorbell_data` bit 24 is 1, so the value 0x01000000 starts it. A doorbell write with bit 24 clear is ignored and produces no output.
- R3: An owned descriptor with length N and address A emits buffer bytes A, A+1, ..., A+N-1 in order, one per `tx_valid` cycle.
- R4: When flag bit 10 (append-check) and bit 11 (frame-end) are both set, the four bytes of `crc_word` follow the data, most significant byte first, and `tx_last` is 1 on the fourth.
- R5: When bit 11 is set and bit 10 is clear, `tx_last` is 1 on the final data byte. A descriptor with bit 11 clear never raises `tx_last`.
- R6: After a descriptor whose bit 13 (wrap) is set, the next descriptor fetched is entry 0. After entry NDESC-1, entry 0 follows even without the wrap flag.
- R7: When the engine reaches a descriptor whose bit 15 (ready) is 0, it stops without output. A later accepted doorbell resumes at that same descriptor.
- R8: On completion, flag bits [5:0] take `inj_status` (bit 0 heartbeat lost, 1 late collision, 2 retry limit, 3 underrun, 4 carrier lost, 5 deferred). Bit 15 becomes 0, and bits 14:6 keep the values the host wrote.
- R9: The status write happens exactly one cycle before the ready flag is cleared, and the ready flag is never cleared at any other time.
- R10: Each completed descriptor with bit 12 (interrupt) set gives a one-cycle `evt_txbuf` pulse. If bit 11 is also set, `evt_txframe` pulses in the same cycle. With bit 12 clear, neither pulse occurs.
- R11: Bit 10 on a descriptor whose bit 11 is clear appends no check bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_desc_we | input | 1 | Write one descriptor |
| host_desc_idx | input | IDX_W | Descriptor index to write |
| host_desc_flags | input | 16 | Flag and status word |
| host_desc_len | input | LEN_W | Byte count |
| host_desc_addr | input | BADDR_W | Start address in the byte buffer |
| host_rd_idx | input | IDX_W | Descriptor index to read back |
| host_rd_flags | output | 16 | Flag word of `host_rd_idx`, one cycle later |
| host_buf_we | input | 1 | Byte buffer write enable |
| host_buf_addr | input | BADDR_W | Byte buffer write address |
| host_buf_wdata | input | 8 | Byte buffer write data |
| doorbell_we | input | 1 | Doorbell register write |
| doorbell_data | input | 32 | Doorbell write value |
| inj_status | input | 6 | Completion status to record |
| crc_word | input | 32 | Check value appended to frames |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| evt_txbuf | output | 1 | Buffer completion pulse |
| evt_txframe | output | 1 | Frame completion pulse |

## Verification
The ring is run with a mix of descriptor types. These are a non-final buffer followed by a check-appended frame end, a plain frame end without interrupt, and a non-final buffer carrying the append flag. Together they separate the `tx_last` placement from the check-byte rule and the per-buffer events from the per-frame events. A rejected doorbell, a stop on a descriptor that is not owned, and a resume at the same entry show that the engine only moves when it should. An explicit wrap, and a pass over all eight entries, show both ways back to entry 0. Flag read-back after each phase shows the recorded status and the returned ownership under several different status patterns.

// File: rtl/tx_bd_pkg.sv
package tx_bd_pkg;
  localparam int FLAG_W    = 16;
  localparam int STAT_W    = 6;
  localparam int FLG_READY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_IRQ   = 12;
  localparam int FLG_LAST  = 11;
  localparam int FLG_CRC   = 10;
  localparam int DB_BIT    = 24;
  localparam int CHK_BYTES = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOAD, S_SEND, S_CHK, S_WB, S_CLR
  } eng_state_t;
endpackage

// File: rtl/tx_desc_store.sv
module tx_desc_store
  import tx_bd_pkg::*;
#(
  parameter int NDESC   = 8,
  parameter int LEN_W   = 11,
  parameter int BADDR_W = 9,
  localparam int IDX_W  = $clog2(NDESC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               h_we,
  input  logic [IDX_W-1:0]   h_idx,
  input  logic [FLAG_W-1:0]  h_flags,
  input  logic [LEN_W-1:0]   h_len,
  input  logic [BADDR_W-1:0] h_addr,
  input  logic [IDX_W-1:0]   h_rd_idx,
  output logic [FLAG_W-1:0]  h_rd_flags,
  input  logic [IDX_W-1:0]   e_idx,
  output logic [FLAG_W-1:0]  e_flags,
  output logic [LEN_W-1:0]   e_len,
  output logic [BADDR_W-1:0] e_addr,
  input  logic               e_stat_wr,
  input  logic [STAT_W-1:0]  e_status,
  input  logic               e_ready_clr
);
  logic [FLAG_W-1:0]  flag_vec [NDESC];
  logic [LEN_W-1:0]   len_mem  [NDESC];
  logic [BADDR_W-1:0] addr_mem [NDESC];

  for (genvar g = 0; g < NDESC; g++) begin : g_ent
    logic [FLAG_W-1:0] ent;
    logic              hit_h, hit_e;
    assign hit_h = h_we && (h_idx == IDX_W'(g));
    assign hit_e = (e_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        ent <= '0;
      end else if (hit_h) begin
        ent <= h_flags;
      end else begin
        if (e_stat_wr && hit_e)   ent[STAT_W-1:0] <= e_status;
        if (e_ready_clr && hit_e) ent[FLG_READY]  <= 1'b0;
      end
    end
    assign flag_vec[g] = ent;
  end

  assign e_flags = flag_vec[e_idx];

  always_ff @(posedge clk) begin
    if (h_we) begin
      len_mem[h_idx]  <= h_len;
      addr_mem[h_idx] <= h_addr;
    end
    e_len  <= len_mem[e_idx];
    e_addr <= addr_mem[e_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) h_rd_flags <= '0;
    else     h_rd_flags <= flag_vec[h_rd_idx];
  end
endmodule

// File: rtl/tx_byte_ram.sv
module tx_byte_ram #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl
  import tx_bd_pkg::*;
#(
  parameter int NDESC   = 8,
  parameter int LEN_W   = 11,
  parameter int BADDR_W = 9,
  localparam int IDX_W  = $clog2(NDESC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [FLAG_W-1:0]  d_flags,
  input  logic [LEN_W-1:0]   d_len,
  input  logic [BADDR_W-1:0] d_addr,
  input  logic [STAT_W-1:0]  inj_status,
  input  logic [31:0]        crc_word,
  output logic [IDX_W-1:0]   ptr,
  output logic               stat_wr,
  output logic [STAT_W-1:0]  status,
  output logic               ready_clr,
  output logic [BADDR_W-1:0] buf_raddr,
  output logic               issue_v,
  output logic               issue_last,
  output logic               issue_chk,
  output logic [7:0]         chk_byte,
  output logic               evt_buf,
  output logic               evt_frame,
  output logic               idle,
  output logic               kick
);
  localparam int KW = $clog2(CHK_BYTES);

  eng_state_t        st;
  logic [LEN_W-1:0]  cnt;
  logic [BADDR_W-1:0] baddr;
  logic [FLAG_W-1:0] cur;
  logic [KW-1:0]     chk_k;
  logic              cur_chk, d_chk;

  assign cur_chk = cur[FLG_CRC] && cur[FLG_LAST];
  assign d_chk   = d_flags[FLG_CRC] && d_flags[FLG_LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ptr        <= '0;
      kick       <= 1'b0;
      cnt        <= '0;
      baddr      <= '0;
      cur        <= '0;
      chk_k      <= '0;
      issue_v    <= 1'b0;
      issue_last <= 1'b0;
      issue_chk  <= 1'b0;
      chk_byte   <= '0;
      evt_buf    <= 1'b0;
      evt_frame  <= 1'b0;
    end else begin
      issue_v    <= 1'b0;
      issue_last <= 1'b0;
      evt_buf    <= 1'b0;
      evt_frame  <= 1'b0;
      if (go && st != S_IDLE) kick <= 1'b1;
      case (st)
        S_IDLE: begin
          if (go || kick) begin
            st   <= S_FETCH;
            kick <= 1'b0;
          end
        end
        S_FETCH: begin
          st <= d_flags[FLG_READY] ? S_LOAD : S_IDLE;
        end
        S_LOAD: begin
          cnt   <= d_len;
          baddr <= d_addr;
          cur   <= d_flags;
          chk_k <= '0;
          if (d_len != '0) st <= S_SEND;
          else if (d_chk)  st <= S_CHK;
          else             st <= S_WB;
        end
        S_SEND: begin
          issue_v    <= 1'b1;
          issue_chk  <= 1'b0;
          issue_last <= (cnt == LEN_W'(1)) && cur[FLG_LAST] && !cur_chk;
          baddr      <= baddr + 1'b1;
          cnt        <= cnt - 1'b1;
          if (cnt == LEN_W'(1)) st <= cur_chk ? S_CHK : S_WB;
        end
        S_CHK: begin
          issue_v    <= 1'b1;
          issue_chk  <= 1'b1;
          chk_byte   <= crc_word[8*(CHK_BYTES-1-int'(chk_k)) +: 8];
          issue_last <= (chk_k == KW'(CHK_BYTES-1));
          chk_k      <= chk_k + 1'b1;
          if (chk_k == KW'(CHK_BYTES-1)) st <= S_WB;
        end
        S_WB: begin
          st <= S_CLR;
        end
        S_CLR: begin
          evt_buf   <= cur[FLG_IRQ];
          evt_frame <= cur[FLG_IRQ] && cur[FLG_LAST];
          ptr       <= cur[FLG_WRAP] ? '0 : ptr + 1'b1;
          st        <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign stat_wr   = (st == S_WB);
  assign ready_clr = (st == S_CLR);
  assign status    = inj_status;
  assign buf_raddr = baddr;
  assign idle      = (st == S_IDLE);
endmodule

// File: rtl/tx_bd_ring.sv
module tx_bd_ring
  import tx_bd_pkg::*;
#(
  parameter int NDESC     = 8,
  parameter int LEN_W     = 11,
  parameter int BUF_DEPTH = 512,
  localparam int IDX_W    = $clog2(NDESC),
  localparam int BADDR_W  = $clog2(BUF_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_desc_we,
  input  logic [IDX_W-1:0]   host_desc_idx,
  input  logic [15:0]        host_desc_flags,
  input  logic [LEN_W-1:0]   host_desc_len,
  input  logic [BADDR_W-1:0] host_desc_addr,
  input  logic [IDX_W-1:0]   host_rd_idx,
  output logic [15:0]        host_rd_flags,
  input  logic               host_buf_we,
  input  logic [BADDR_W-1:0] host_buf_addr,
  input  logic [7:0]         host_buf_wdata,
  input  logic               doorbell_we,
  input  logic [31:0]        doorbell_data,
  input  logic [5:0]         inj_status,
  input  logic [31:0]        crc_word,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  output logic               evt_txbuf,
  output logic               evt_txframe
);
  logic               go;
  logic [IDX_W-1:0]   ptr;
  logic [FLAG_W-1:0]  d_flags;
  logic [LEN_W-1:0]   d_len;
  logic [BADDR_W-1:0] d_addr;
  logic               stat_wr, ready_clr, eng_idle, kick_pend;
  logic [STAT_W-1:0]  status;
  logic [BADDR_W-1:0] buf_raddr;
  logic [7:0]         buf_q, chk_byte;
  logic               issue_chk;

  assign go = doorbell_we && doorbell_data[DB_BIT];

  tx_desc_store #(.NDESC(NDESC), .LEN_W(LEN_W), .BADDR_W(BADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .h_we(host_desc_we), .h_idx(host_desc_idx), .h_flags(host_desc_flags),
    .h_len(host_desc_len), .h_addr(host_desc_addr),
    .h_rd_idx(host_rd_idx), .h_rd_flags(host_rd_flags),
    .e_idx(ptr), .e_flags(d_flags), .e_len(d_len), .e_addr(d_addr),
    .e_stat_wr(stat_wr), .e_status(status), .e_ready_clr(ready_clr)
  );

  tx_byte_ram #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .we(host_buf_we), .waddr(host_buf_addr), .wdata(host_buf_wdata),
    .raddr(buf_raddr), .rdata(buf_q)
  );

  tx_ring_ctrl #(.NDESC(NDESC), .LEN_W(LEN_W), .BADDR_W(BADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .go(go),
    .d_flags(d_flags), .d_len(d_len), .d_addr(d_addr),
    .inj_status(inj_status), .crc_word(crc_word),
    .ptr(ptr), .stat_wr(stat_wr), .status(status), .ready_clr(ready_clr),
    .buf_raddr(buf_raddr), .issue_v(tx_valid), .issue_last(tx_last),
    .issue_chk(issue_chk), .chk_byte(chk_byte),
    .evt_buf(evt_txbuf), .evt_frame(evt_txframe),
    .idle(eng_idle), .kick(kick_pend)
  );

  assign tx_data = issue_chk ? chk_byte : buf_q;
endmodule

// File: rtl/tx_bd_ring_chk.sv
module tx_bd_ring_chk (
  input logic        clk,
  input logic        rst,
  input logic        tx_valid,
  input logic        tx_last,
  input logic        evt_txbuf,
  input logic        evt_txframe,
  input logic        stat_wr,
  input logic        ready_clr,
  input logic        eng_idle,
  input logic        kick_pend,
  input logic        doorbell_we,
  input logic [31:0] doorbell_data
);
  p_frame_has_buf_r10: assert property (@(posedge clk) disable iff (rst)
    evt_txframe |-> evt_txbuf);

  p_buf_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    evt_txbuf |=> !evt_txbuf);

  p_last_is_valid_r5: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  p_status_then_clear_r9: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> ready_clr);

  p_clear_follows_status_r9: assert property (@(posedge clk) disable iff (rst)
    ready_clr |-> $past(stat_wr));

  p_bad_doorbell_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (eng_idle && !kick_pend && doorbell_we && !doorbell_data[24]) |=> eng_idle);
endmodule

bind tx_bd_ring tx_bd_ring_chk u_chk (.*);

// File: tb/tb_tx_bd_ring.sv
module tb_tx_bd_ring;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] F_READY = 16'h8000;
  localparam logic [15:0] F_WRAP  = 16'h2000;
  localparam logic [15:0] F_IRQ   = 16'h1000;
  localparam logic [15:0] F_LAST  = 16'h0800;
  localparam logic [15:0] F_CRC   = 16'h0400;

  logic        clk = 1'b0, rst = 1'b1;
  logic        host_desc_we = 0;
  logic [2:0]  host_desc_idx = 0;
  logic [15:0] host_desc_flags = 0;
  logic [10:0] host_desc_len = 0;
  logic [8:0]  host_desc_addr = 0;
  logic [2:0]  host_rd_idx = 0;
  logic [15:0] host_rd_flags;
  logic        host_buf_we = 0;
  logic [8:0]  host_buf_addr = 0;
  logic [7:0]  host_buf_wdata = 0;
  logic        doorbell_we = 0;
  logic [31:0] doorbell_data = 0;
  logic [5:0]  inj_status = 0;
  logic [31:0] crc_word = 32'hA1B2C3D4;
  logic        tx_valid, tx_last, evt_txbuf, evt_txframe;
  logic [7:0]  tx_data;

  tx_bd_ring dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [7:0] mem_model [512];
  logic [8:0] q_data [$];
  logic [1:0] q_evt  [$];
  logic [15:0] orig [8];
  logic       mon_on = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  // per-cycle comparison against the behavioural model queues
  always @(negedge clk) begin
    if (mon_on) begin
      if (tx_valid) begin
        if (q_data.size() == 0) chk(1'b0, "R3 unexpected byte", {23'd0, tx_last, tx_data}, 32'hFFFF);
        else begin
          logic [8:0] e;
          e = q_data.pop_front();
          chk({tx_last, tx_data} == e, "R3/R4/R5 byte", {23'd0, tx_last, tx_data}, {23'd0, e});
        end
      end
      if (evt_txbuf || evt_txframe) begin
        if (q_evt.size() == 0) chk(1'b0, "R10 unexpected event", {30'd0, evt_txbuf, evt_txframe}, 0);
        else begin
          logic [1:0] e;
          e = q_evt.pop_front();
          chk({evt_txbuf, evt_txframe} == e, "R10 event", {30'd0, evt_txbuf, evt_txframe}, {30'd0, e});
        end
      end
    end
  end

  task automatic put_desc(input int idx, input int len, input int addr, input logic [15:0] fl);
    bit last, crc;
    @(negedge clk);
    host_desc_we = 1; host_desc_idx = 3'(idx); host_desc_flags = fl;
    host_desc_len = 11'(len); host_desc_addr = 9'(addr);
    @(negedge clk);
    host_desc_we = 0;
    orig[idx] = fl;
  endtask

  // model: queue what a descriptor will produce once the engine reaches it
  task automatic expect_desc(input int len, input int addr, input logic [15:0] fl);
    bit last, crc;
    last = fl[11];
    crc  = fl[10] && last;
    for (int i = 0; i < len; i++)
      q_data.push_back({last && !crc && (i == len-1), mem_model[(addr+i) % 512]});
    if (crc)
      for (int k = 0; k < 4; k++) q_data.push_back({k == 3, crc_word[8*(3-k) +: 8]});
    if (fl[12]) q_evt.push_back({1'b1, last});
  endtask

  task automatic ring(input logic [31:0] v);
    @(negedge clk);
    doorbell_we = 1; doorbell_data = v;
    @(negedge clk);
    doorbell_we = 0;
  endtask

  task automatic read_flags(input int idx, output logic [15:0] v);
    @(negedge clk);
    host_rd_idx = 3'(idx);
    @(negedge clk);
    v = host_rd_flags;
  endtask

  task automatic check_flags(input int idx, input logic [5:0] st, input string req);
    logic [15:0] v, e;
    read_flags(idx, v);
    e = (orig[idx] & ~F_READY & 16'hFFC0) | {10'd0, st};
    chk(v == e, req, {16'd0, v}, {16'd0, e});
  endtask

  task automatic phase_end(input string req);
    repeat (80) @(negedge clk);
    chk(q_data.size() == 0, req, q_data.size(), 0);
    chk(q_evt.size() == 0, req, q_evt.size(), 0);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(!tx_valid && !tx_last, "R1 outputs", {30'd0, tx_valid, tx_last}, 0);
    chk(!evt_txbuf && !evt_txframe, "R1 events", {30'd0, evt_txbuf, evt_txframe}, 0);
    read_flags(0, v);
    chk(v == 16'h0, "R1 flags", {16'd0, v}, 0);

    for (int i = 0; i < 512; i++) begin
      mem_model[i] = 8'((i * 7 + 3) ^ (i >> 3));
      @(negedge clk);
      host_buf_we = 1; host_buf_addr = 9'(i); host_buf_wdata = mem_model[i];
    end
    @(negedge clk); host_buf_we = 0;
    for (int i = 0; i < 8; i++) put_desc(i, 1, 0, 16'h0);
    mon_on = 1;

    // phase 1: R2 rejected doorbell, then R3/R4/R10 frame of two buffers
    put_desc(0, 5, 10, F_READY | F_IRQ);
    put_desc(1, 3, 100, F_READY | F_IRQ | F_LAST | F_CRC);
    inj_status = 6'b100001;
    ring(32'h0000_0001);
    ring(32'h00FF_FFFF);
    phase_end("R2 ignored doorbell");
    expect_desc(5, 10, orig[0]);
    expect_desc(3, 100, orig[1]);
    ring(32'h0100_0000);
    phase_end("R3/R4 phase1 drained");
    check_flags(0, 6'b100001, "R8 status d0");
    check_flags(1, 6'b100001, "R8 status d1");

    // phase 2: R7 resume at d2; R5 plain frame end; R11 append on non-final
    put_desc(2, 4, 200, F_READY | F_LAST);
    put_desc(3, 2, 300, F_READY | F_IRQ | F_CRC);
    inj_status = 6'b010110;
    expect_desc(4, 200, orig[2]);
    expect_desc(2, 300, orig[3]);
    ring(32'h0100_0000);
    phase_end("R7/R5/R11 phase2 drained");
    check_flags(2, 6'b010110, "R8 status d2");
    check_flags(3, 6'b010110, "R11 flags d3");

    // phase 3: R6 explicit wrap from d4 to d0
    put_desc(4, 3, 50, F_READY | F_IRQ | F_LAST | F_WRAP);
    put_desc(0, 2, 400, F_READY | F_IRQ | F_LAST | F_CRC);
    inj_status = 6'b001000;
    expect_desc(3, 50, orig[4]);
    expect_desc(2, 400, orig[0]);
    ring(32'h0100_0000);
    phase_end("R6 wrap flag");
    check_flags(4, 6'b001000, "R8 status d4");

    // phase 4: R6 natural wrap after the final entry
    for (int i = 1; i < 8; i++) put_desc(i, 1, 500 + i, F_READY | F_LAST);
    put_desc(0, 1, 20, F_READY | F_IRQ | F_LAST);
    inj_status = 6'b000000;
    for (int i = 1; i < 8; i++) expect_desc(1, 500 + i, orig[i]);
    expect_desc(1, 20, orig[0]);
    ring(32'h0100_0000);
    phase_end("R6 natural wrap");
    check_flags(7, 6'b000000, "R8 status d7");
    check_flags(0, 6'b000000, "R6 status d0");
    mon_on = 0;
    finish_run();
  end
endmodule